// File: doc/BRIEF.md
# Atomic Memory Operation Unit

This block owns a single-ported word memory and serves several requesters that need indivisible read-modify-write access to it. Each requester presents an operation code, a word address and a write value. The block picks one requester by fixed priority and holds the memory port for a read cycle followed by a write cycle. No other request can slip between the read and the write. It then returns one result word to that requester.

The supported operations are plain load and store, exchange, test-and-set, fetch-and-increment, and a linked load paired with a conditional store. The block keeps one link per requester, made of a valid bit and a word address. Any write that lands on a linked address breaks every link on that address. A conditional store consumes the link of the requester that issues it. Software builds spin locks on top of these operations, where 0 means free and 1 means held, and lock-free updates on top of the linked pair.

Top module: `amo_unit`

## Requirements
- R1: Operation codes on each 3-bit field of `req_op` are 0 load, 1 store, 2 exchange, 3 test-and-set, 4 fetch-and-increment, 5 linked load, 6 conditional store, and 7 acts as a load. When several requesters are valid, the lowest index wins. `req_grant` is one-hot, or zero when no request is accepted.
- R2: A grant is a single-cycle pulse. The cycle after a grant never carries another grant, so each operation owns the memory for two cycles.
- R3: `rsp_valid` pulses for the granted requester alone, exactly two cycles after its grant, with the result on `rsp_data`.
- R4: A load returns the word and leaves it unchanged. A store writes the new value and returns the previous word.
- R5: An exchange returns the previous word and writes the new value. On a lock word, a returned 0 means the lock was taken.
- R6: Test-and-set returns the previous word and writes 1 only when that word was 0. Otherwise it writes nothing.
- R7: Fetch-and-increment returns the previous word and writes it plus one, wrapping from all ones to zero.
- R8: A linked load returns the word and records a link for the issuing requester at that address, replacing any earlier link of that requester.
- R9: A conditional store whose requester still holds a link on the same address writes its value and returns 1.
- R10: A conditional store returns 0 and writes nothing in these cases: no link, a link on another address, or a link broken by a write to that address (store, exchange, increment, successful test-and-set or successful conditional store) since it was made. Every conditional store consumes its own link.
- R11: Reset clears all links and leaves `req_grant` and `rsp_valid` low. Memory contents are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NREQ | Request pending, one bit per requester, held until granted |
| req_op | input | 3*NREQ | Operation code per requester, requester i at bits [3i+2:3i] |
| req_addr | input | AW*NREQ | Word address per requester |
| req_wdata | input | DW*NREQ | Write value per requester |
| req_grant | output | NREQ | One-hot pulse when a request is accepted |
| rsp_valid | output | NREQ | One-hot pulse when the result for that requester is on rsp_data |
| rsp_data | output | DW | Previous word, or 1/0 for a conditional store |

## Verification
The bench builds the block with four requesters, a 16-word memory and 16-bit words. Random traffic aims at only four addresses, so links are broken by other requesters' writes all the time, and all four priority positions contend. The 16-bit word lets a directed fetch-and-increment cross the all-ones wrap. A reset in the middle of the run, between a linked load and its conditional store, shows that links do not survive reset.

// File: rtl/amo_pkg.sv
package amo_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_XCHG  = 3'd2,
        OP_TAS   = 3'd3,
        OP_FINC  = 3'd4,
        OP_LINK  = 3'd5,
        OP_CSTR  = 3'd6,
        OP_RSVD  = 3'd7
    } amo_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RMW  = 1'b1
    } amo_state_e;

    function automatic logic op_breaks_links(amo_op_e op);
        return (op == OP_STORE) || (op == OP_XCHG) || (op == OP_FINC);
    endfunction

endpackage

// File: rtl/amo_arbiter.sv
module amo_arbiter #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic          en,
    input  logic [N-1:0]  valid,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] idx
);
    always_comb begin
        grant = '0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (en && valid[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                idx      = IW'(i);
            end
        end
    end
endmodule

// File: rtl/amo_resv.sv
module amo_resv #(
    parameter int N  = 4,
    parameter int AW = 10,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          set_en,
    input  logic          own_clr_en,
    input  logic          wr_en,
    input  logic [IW-1:0] id,
    input  logic [AW-1:0] addr,
    output logic          hit
);
    logic          lnk_v [N];
    logic [AW-1:0] lnk_a [N];

    for (genvar g = 0; g < N; g++) begin : g_link
        always_ff @(posedge clk) begin
            if (rst) begin
                lnk_v[g] <= 1'b0;
                lnk_a[g] <= '0;
            end else if (set_en && (id == IW'(g))) begin
                lnk_v[g] <= 1'b1;
                lnk_a[g] <= addr;
            end else if ((wr_en && lnk_v[g] && (lnk_a[g] == addr)) ||
                         (own_clr_en && (id == IW'(g)))) begin
                lnk_v[g] <= 1'b0;
            end
        end
    end

    assign hit = lnk_v[id] && (lnk_a[id] == addr);
endmodule

// File: rtl/amo_wordmem.sv
module amo_wordmem #(
    parameter int AW = 10,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                store_q[addr] <= wdata;
            end else begin
                rdata <= store_q[addr];
            end
        end
    end
endmodule

// File: rtl/amo_alu.sv
module amo_alu
    import amo_pkg::*;
#(
    parameter int DW = 32
) (
    input  amo_op_e       op,
    input  logic [DW-1:0] old_val,
    input  logic [DW-1:0] new_val,
    input  logic          link_ok,
    output logic          wr_en,
    output logic [DW-1:0] wr_val,
    output logic [DW-1:0] result
);
    always_comb begin
        wr_en  = op_breaks_links(op);
        wr_val = new_val;
        result = old_val;
        unique case (op)
            OP_TAS: begin
                wr_en  = (old_val == '0);
                wr_val = DW'(1);
            end
            OP_FINC: begin
                wr_val = old_val + DW'(1);
            end
            OP_CSTR: begin
                wr_en  = link_ok;
                result = DW'(link_ok);
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/amo_unit.sv
module amo_unit
    import amo_pkg::*;
#(
    parameter int NREQ = 4,
    parameter int AW   = 10,
    parameter int DW   = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NREQ-1:0]      req_valid,
    input  logic [OP_W*NREQ-1:0] req_op,
    input  logic [AW*NREQ-1:0]   req_addr,
    input  logic [DW*NREQ-1:0]   req_wdata,
    output logic [NREQ-1:0]      req_grant,
    output logic [NREQ-1:0]      rsp_valid,
    output logic [DW-1:0]        rsp_data
);
    localparam int IW = (NREQ > 1) ? $clog2(NREQ) : 1;

    amo_state_e    state_q;
    amo_op_e       cur_op;
    logic [IW-1:0] cur_id;
    logic [AW-1:0] cur_addr;
    logic [DW-1:0] cur_wdata;

    logic [IW-1:0] sel_id;
    logic [AW-1:0] sel_addr;
    logic          grant_en;
    logic          take;
    logic          in_rmw;

    logic          mem_en;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_rdata;

    logic          link_hit;
    logic          alu_we;
    logic [DW-1:0] alu_wval;
    logic [DW-1:0] alu_res;

    assign grant_en = (state_q == ST_IDLE) && !rst;
    assign in_rmw   = (state_q == ST_RMW);
    assign take     = |req_grant;
    assign sel_addr = req_addr[int'(sel_id)*AW +: AW];

    amo_arbiter #(.N(NREQ), .IW(IW)) u_arb (
        .en    (grant_en),
        .valid (req_valid),
        .grant (req_grant),
        .idx   (sel_id)
    );

    assign mem_en   = take || in_rmw;
    assign mem_we   = in_rmw && alu_we;
    assign mem_addr = in_rmw ? cur_addr : sel_addr;

    amo_wordmem #(.AW(AW), .DW(DW)) u_mem (
        .clk   (clk),
        .en    (mem_en),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (alu_wval),
        .rdata (mem_rdata)
    );

    amo_resv #(.N(NREQ), .AW(AW), .IW(IW)) u_resv (
        .clk        (clk),
        .rst        (rst),
        .set_en     (in_rmw && (cur_op == OP_LINK)),
        .own_clr_en (in_rmw && (cur_op == OP_CSTR)),
        .wr_en      (mem_we),
        .id         (cur_id),
        .addr       (cur_addr),
        .hit        (link_hit)
    );

    amo_alu #(.DW(DW)) u_alu (
        .op      (cur_op),
        .old_val (mem_rdata),
        .new_val (cur_wdata),
        .link_ok (link_hit),
        .wr_en   (alu_we),
        .wr_val  (alu_wval),
        .result  (alu_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            cur_op    <= OP_LOAD;
            cur_id    <= '0;
            cur_addr  <= '0;
            cur_wdata <= '0;
            rsp_valid <= '0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= '0;
            unique case (state_q)
                ST_IDLE: begin
                    if (take) begin
                        cur_op    <= amo_op_e'(req_op[int'(sel_id)*OP_W +: OP_W]);
                        cur_id    <= sel_id;
                        cur_addr  <= sel_addr;
                        cur_wdata <= req_wdata[int'(sel_id)*DW +: DW];
                        state_q   <= ST_RMW;
                    end
                end
                ST_RMW: begin
                    rsp_valid <= NREQ'(1) << cur_id;
                    rsp_data  <= alu_res;
                    state_q   <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/amo_checker.sv
module amo_checker #(
    parameter int NREQ = 4
) (
    input logic            clk,
    input logic            rst,
    input logic [NREQ-1:0] req_valid,
    input logic [NREQ-1:0] req_grant,
    input logic [NREQ-1:0] rsp_valid
);
    p_grant_onehot_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(req_grant));

    p_lowest_wins_r1: assert property (@(posedge clk) disable iff (rst)
        (req_grant != '0) |->
            (((req_grant & req_valid) != '0) &&
             ((req_valid & (req_grant - NREQ'(1))) == '0)));

    p_no_back_to_back_r2: assert property (@(posedge clk) disable iff (rst)
        (req_grant != '0) |=> (req_grant == '0));

    p_rsp_after_two_r3: assert property (@(posedge clk) disable iff (rst)
        (req_grant != '0) |-> ##2 (rsp_valid == $past(req_grant, 2)));

    p_rsp_has_source_r3: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid != '0) |-> (rsp_valid == $past(req_grant, 2)));

    p_rsp_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rsp_valid));
endmodule

bind amo_unit amo_checker #(.NREQ(NREQ)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_grant (req_grant),
    .rsp_valid (rsp_valid)
);

// File: tb/amo_unit_tb.sv
`timescale 1ns/1ps
module amo_unit_tb;
    localparam int N  = 4;
    localparam int AW = 4;
    localparam int DW = 16;
    localparam int WORDS = 1 << AW;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N-1:0]    req_valid = '0;
    logic [3*N-1:0]  req_op    = '0;
    logic [AW*N-1:0] req_addr  = '0;
    logic [DW*N-1:0] req_wdata = '0;
    logic [N-1:0]    req_grant;
    logic [N-1:0]    rsp_valid;
    logic [DW-1:0]   rsp_data;

    amo_unit #(.NREQ(N), .AW(AW), .DW(DW)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_grant(req_grant),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    always #5 clk = ~clk;

    // reference model state
    logic [DW-1:0] mm [WORDS];
    bit            mk [WORDS];
    bit            rv [N];
    logic [AW-1:0] ra [N];

    // pending requests per requester
    bit            pset [N];
    logic [2:0]    pop  [N];
    logic [AW-1:0] pad  [N];
    logic [DW-1:0] pwd  [N];

    logic [N-1:0]  p1m = '0, p2m = '0, drop = '0;
    logic [DW-1:0] e1 = '0, e2 = '0;
    bit            k1, k2, gprev, rnd_on;
    string         t1, t2;
    int            n_chk = 0, n_fail = 0;

    function automatic string tag_of(logic [2:0] op, logic [DW-1:0] r);
        case (op)
            3'd1:    return "R4";
            3'd2:    return "R5";
            3'd3:    return "R6";
            3'd4:    return "R7";
            3'd5:    return "R8";
            3'd6:    return (r == 1) ? "R9" : "R10";
            default: return "R4";
        endcase
    endfunction

    task automatic break_links(logic [AW-1:0] a);
        for (int j = 0; j < N; j++) if (rv[j] && ra[j] == a) rv[j] = 0;
    endtask

    task automatic model(int id, logic [2:0] op, logic [AW-1:0] a, logic [DW-1:0] d,
                         output logic [DW-1:0] r, output bit known);
        r = mm[a];
        known = mk[a];
        case (op)
            3'd1, 3'd2: begin mm[a] = d; mk[a] = 1; break_links(a); end
            3'd3: if (known && mm[a] == 0) begin mm[a] = 1; break_links(a); end
            3'd4: begin mm[a] = mm[a] + 1'b1; break_links(a); end
            3'd5: begin rv[id] = 1; ra[id] = a; end
            3'd6: begin
                known = 1;
                if (rv[id] && ra[id] == a) begin
                    r = 1; mm[a] = d; mk[a] = 1; break_links(a);
                end else r = 0;
                rv[id] = 0;
            end
            default: ;
        endcase
    endtask

    task automatic step_a();
        if (gprev) begin
            n_chk++;
            if (req_grant != '0) begin
                n_fail++;
                $display("FAIL R2 grant in cycle after grant: actual %b expected 0", req_grant);
            end
        end
        n_chk++;
        if (rsp_valid !== p2m) begin
            n_fail++;
            $display("FAIL R3 rsp_valid actual %b expected %b", rsp_valid, p2m);
        end else if (p2m != '0 && k2 && rsp_data !== e2) begin
            n_fail++;
            $display("FAIL %s rsp_data actual %h expected %h", t2, rsp_data, e2);
        end
        p2m = p1m; e2 = e1; k2 = k1; t2 = t1; p1m = '0;
        req_valid = req_valid & ~drop;
        drop = '0;
        if (rnd_on) begin
            for (int i = 0; i < N; i++) begin
                if (!pset[i] && !req_valid[i] && $urandom_range(0, 2) == 0) begin
                    pset[i] = 1;
                    pop[i]  = 3'($urandom_range(0, 6));
                    pad[i]  = AW'($urandom_range(0, 3));
                    pwd[i]  = ($urandom_range(0, 1) == 1) ? DW'($urandom) : DW'($urandom_range(0, 1));
                end
            end
        end
        for (int i = 0; i < N; i++) begin
            if (pset[i] && !req_valid[i]) begin
                pset[i] = 0;
                req_op[i*3 +: 3]     = pop[i];
                req_addr[i*AW +: AW] = pad[i];
                req_wdata[i*DW +: DW] = pwd[i];
                req_valid[i] = 1'b1;
            end
        end
    endtask

    task automatic step_b();
        logic [N-1:0] lw;
        logic [DW-1:0] r;
        bit kn;
        int id;
        gprev = (req_grant != '0);
        if (req_grant != '0) begin
            lw = req_valid & (~req_valid + 1'b1);
            n_chk++;
            if (req_grant !== lw) begin
                n_fail++;
                $display("FAIL R1 grant actual %b expected %b", req_grant, lw);
            end
            id = 0;
            for (int i = 0; i < N; i++) if (req_grant[i]) id = i;
            model(id, req_op[id*3 +: 3], req_addr[id*AW +: AW], req_wdata[id*DW +: DW], r, kn);
            e1 = r; k1 = kn; t1 = tag_of(req_op[id*3 +: 3], r);
            p1m = req_grant;
            drop = req_grant;
        end
    endtask

    task automatic cycle();
        @(negedge clk);
        step_a();
        #1;
        step_b();
    endtask

    task automatic post(int id, logic [2:0] op, logic [AW-1:0] a, logic [DW-1:0] d);
        pset[id] = 1; pop[id] = op; pad[id] = a; pwd[id] = d;
    endtask

    function automatic bit quiet();
        bit any = 0;
        for (int i = 0; i < N; i++) any |= pset[i];
        return !any && req_valid == '0 && p1m == '0 && p2m == '0 && drop == '0;
    endfunction

    task automatic drain();
        for (int k = 0; k < 60; k++) begin
            cycle();
            if (quiet()) break;
        end
        if (!quiet()) begin
            n_chk++; n_fail++;
            $display("FAIL R3 requests not completed: actual busy expected idle");
        end
        cycle();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        n_chk++;
        if (req_grant !== '0 || rsp_valid !== '0) begin
            n_fail++;
            $display("FAIL R11 in reset grant/rsp actual %b/%b expected 0/0", req_grant, rsp_valid);
        end
        for (int i = 0; i < N; i++) rv[i] = 0;
        gprev = 0;
        rst = 1'b0;
    endtask

    initial begin
        #2_000_000;
        $display("FAIL watchdog expired: actual running expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_fail + 1);
        $finish;
    end

    initial begin
        for (int a = 0; a < WORDS; a++) begin mm[a] = '0; mk[a] = 0; end
        for (int i = 0; i < N; i++) begin rv[i] = 0; ra[i] = '0; pset[i] = 0; end
        rnd_on = 0; gprev = 0; k1 = 0; k2 = 0;
        void'($urandom(32'd1234));

        // R11: reset state
        do_reset();
        @(negedge clk);
        n_chk++;
        if (req_grant !== '0 || rsp_valid !== '0) begin
            n_fail++;
            $display("FAIL R11 after reset grant/rsp actual %b/%b expected 0/0", req_grant, rsp_valid);
        end

        // R10/R11: conditional store with no link after reset
        post(2, 3'd6, 4'd9, 16'h1111); drain();

        // fill memory, R4
        for (int a = 0; a < WORDS; a++) begin post(0, 3'd1, AW'(a), '0); drain(); end
        post(3, 3'd0, 4'd9, '0); drain();

        // R5 lock acquire then contention
        post(0, 3'd2, 4'd0, 16'd1); drain();
        post(1, 3'd2, 4'd0, 16'd1); drain();
        post(2, 3'd1, 4'd0, 16'd0); drain();

        // R6 test-and-set taken, then refused
        post(2, 3'd3, 4'd1, '0); drain();
        post(3, 3'd3, 4'd1, '0); drain();
        post(3, 3'd0, 4'd1, '0); drain();

        // R7 increment wraps
        post(1, 3'd1, 4'd2, 16'hFFFF); drain();
        post(1, 3'd4, 4'd2, '0); drain();
        post(0, 3'd0, 4'd2, '0); drain();

        // R8/R9 linked pair succeeds, R10 second use fails
        post(1, 3'd5, 4'd3, '0); drain();
        post(1, 3'd6, 4'd3, 16'h0055); drain();
        post(2, 3'd0, 4'd3, '0); drain();
        post(1, 3'd6, 4'd3, 16'h0066); drain();

        // R10 link broken by another requester's store
        post(0, 3'd5, 4'd4, '0); drain();
        post(2, 3'd1, 4'd4, 16'h0077); drain();
        post(0, 3'd6, 4'd4, 16'h0099); drain();
        post(0, 3'd0, 4'd4, '0); drain();

        // R9/R10 two links, first conditional store wins
        post(0, 3'd5, 4'd6, '0); drain();
        post(1, 3'd5, 4'd6, '0); drain();
        post(1, 3'd6, 4'd6, 16'h00AA); drain();
        post(0, 3'd6, 4'd6, 16'h00BB); drain();

        // R10 link on another address
        post(3, 3'd5, 4'd8, '0); drain();
        post(3, 3'd6, 4'd5, 16'h0001); drain();

        // R1 simultaneous requests, mixed ops
        post(3, 3'd4, 4'd7, '0);
        post(1, 3'd2, 4'd7, 16'h0010);
        post(2, 3'd0, 4'd7, '0);
        drain();

        // R11 reset breaks a link
        post(2, 3'd5, 4'd10, '0); drain();
        do_reset();
        post(2, 3'd6, 4'd10, 16'h0033); drain();
        post(2, 3'd0, 4'd10, '0); drain();

        // random contention
        rnd_on = 1;
        for (int c = 0; c < 3000; c++) cycle();
        rnd_on = 0;
        drain();

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule